// File: doc/BRIEF.md
# Pulse Position Symbol Decoder

This block recovers short reader commands sent as 1-of-16 pulse-position symbols. The demodulator in front of it delivers an active-low gap signal. The decoder waits for a calibration gap of legal width. It takes the end of that gap as the time origin and then splits the time that follows into consecutive symbol windows. Each window holds sixteen equal positions. The position in which a data gap begins gives a 4-bit value. Three such values are packed into a 12-bit command word, which goes to a downstream command decoder with a one-clock strobe and a parity flag.

All timing is counted in ticks of a time-base enable input. Two timing sets are supported. The normal set has long positions and wide gaps. The fast set has short positions and narrow gaps. The set is chosen by a mode input and sampled when the calibration gap begins, so it stays fixed for the whole command. A window with no usable gap, or with two of them, aborts the command. Gaps that are too narrow or too wide count as noise and are dropped.

Top module: `ppm_sym_decoder`

## Requirements
- R1: After reset, word_o is 0 and word_valid_o, parity_err_o and sym_err_o are all 0.
- R2: In the idle state, a low pulse on gap_n whose width in ticks lies within the current mode's [min,max] gap range arms the decoder. The first high tick after the pulse is time t=0. A calibration pulse outside that range leaves the decoder idle, so no word and no error follow from it.
- R3: A data gap whose first low tick falls at time t is assigned position floor((t - 16*P*s)/P) in symbol window s (s = 0, 1, 2). A gap that starts exactly on a position boundary belongs to the later position. The 4-bit value is the position index, 0 to 15.
- R4: With fast_mode low at the start of calibration, P = POS_N and the legal gap width is GMIN_N..GMAX_N ticks (defaults 16, 3, 10).
- R5: With fast_mode high at the start of calibration, P = POS_F and the legal gap width is GMIN_F..GMAX_F ticks (defaults 8, 2, 4).
- R6: Within a window, a gap narrower than the minimum or wider than the maximum is ignored. The legal gap in the same window still decodes correctly.
- R7: A window that ends without a legal gap pulses sym_err_o for one clock. The word is discarded (no word_valid_o) and the decoder returns to idle.
- R8: A window with two or more legal gaps pulses sym_err_o and discards the word.
- R9: word_valid_o pulses for one clock right after the tick that ends the third window. word_o carries the first symbol in bits 11:8, the second in 7:4 and the third in 3:0. word_o holds its value until the next valid word.
- R10: parity_err_o, valid together with word_valid_o, is 1 exactly when word_o holds an odd number of ones. Bit 0 is an even-parity bit over bits 11:1.
- R11: After a word or an error, the decoder goes back to idle and needs a new calibration pulse. A change of fast_mode during a command does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable; one tick per asserted cycle |
| fast_mode | input | 1 | Selects fast timing when high, sampled at calibration start |
| gap_n | input | 1 | Demodulated gap signal, low during a gap |
| word_o | output | 12 | Assembled command word |
| word_valid_o | output | 1 | One-clock strobe for a new word |
| parity_err_o | output | 1 | Parity error of the word just strobed |
| sym_err_o | output | 1 | One-clock strobe when a window has no legal gap or more than one |

## Verification
The bench places gaps exactly on a position boundary and on the last tick before one. A decoder that rounds, or that counts from the wrong origin, would then report the neighbouring value. It puts too-narrow and too-wide pulses next to legal gaps, and feeds too-narrow and too-wide calibration pulses. A width check that is off by one would then either corrupt the word or arm on noise, and arming on noise shows up as a later symbol error. Empty and doubly filled windows must give exactly one error strobe and no word. Toggling the mode in the middle of a command must leave the decoded word intact, which shows whether the mode is held across the command.

// File: rtl/ppm_pkg.sv
`timescale 1ns/1ps
package ppm_pkg;
  localparam int SLOTS = 16;
  localparam int NIB_W = 4;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_RUN  = 2'd2
  } dec_st_e;
endpackage

// File: rtl/ppm_gap_meter.sv
`timescale 1ns/1ps
module ppm_gap_meter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gap,
  input  logic [CW-1:0] min_w,
  input  logic [CW-1:0] max_w,
  output logic          fall,
  output logic          rise,
  output logic          rise_ok
);
  localparam logic [CW-1:0] WSAT = '1;

  logic          gap_q;
  logic [CW-1:0] wcnt, wcnt_d;

  always_comb begin
    fall    = tick & gap & ~gap_q;
    rise    = tick & ~gap & gap_q;
    rise_ok = rise & (wcnt >= min_w) & (wcnt <= max_w);
    wcnt_d  = wcnt;
    if (fall)
      wcnt_d = {{(CW-1){1'b0}}, 1'b1};
    else if (gap && wcnt != WSAT)
      wcnt_d = wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= 1'b0;
      wcnt  <= '0;
    end else if (tick) begin
      gap_q <= gap;
      wcnt  <= wcnt_d;
    end
  end

  AST_WIDTH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gap && gap_q && wcnt != WSAT) |=> (wcnt == $past(wcnt) + 1'b1)); // R6
endmodule

// File: rtl/ppm_slot_timer.sv
`timescale 1ns/1ps
module ppm_slot_timer
  import ppm_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             run,
  input  logic [PW-1:0]    pos_len,
  output logic [NIB_W-1:0] slot,
  output logic             win_end
);
  logic [PW-1:0]    pos_cnt, pos_cnt_d;
  logic [NIB_W-1:0] slot_d;
  logic             pos_last, en;

  always_comb begin
    pos_last  = (pos_cnt == pos_len - 1'b1);
    win_end   = tick & run & pos_last & (slot == NIB_W'(SLOTS-1));
    en        = tick & (start | run);
    pos_cnt_d = pos_cnt;
    slot_d    = slot;
    if (start) begin
      pos_cnt_d = PW'(1);
      slot_d    = '0;
    end else if (pos_last) begin
      pos_cnt_d = '0;
      slot_d    = slot + 1'b1;
    end else begin
      pos_cnt_d = pos_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_cnt <= '0;
      slot    <= '0;
    end else if (en) begin
      pos_cnt <= pos_cnt_d;
      slot    <= slot_d;
    end
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !start && pos_last) |=> (slot == $past(slot) + 1'b1)); // R3
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos_cnt < pos_len)); // R4
endmodule

// File: rtl/ppm_word_asm.sv
`timescale 1ns/1ps
module ppm_word_asm
  import ppm_pkg::*;
#(
  parameter  int SYMS   = 3,
  localparam int WORD_W = SYMS * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic              fall,
  input  logic              rise,
  input  logic              rise_ok,
  input  logic [NIB_W-1:0]  slot,
  input  logic              win_end,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              parity_err_o,
  output logic              sym_err_o,
  output logic              done
);
  localparam int SCW = (SYMS > 1) ? $clog2(SYMS) : 1;

  logic [NIB_W-1:0]  cand, cand_d, hit, hit_d, new_nib;
  logic              have, have_d, multi, multi_d, in_gap, in_gap_d;
  logic [SCW-1:0]    sym_cnt, sym_cnt_d;
  logic [WORD_W-1:0] acc, acc_d, acc_nx, word_d;
  logic              valid_d, perr_d, serr_d;
  logic              comp, one_ok, last_sym;

  always_comb begin
    comp     = run & in_gap & rise_ok;
    one_ok   = (have & ~multi & ~comp) | (~have & comp);
    new_nib  = have ? hit : cand;
    acc_nx   = {acc[WORD_W-NIB_W-1:0], new_nib};
    last_sym = (sym_cnt == SCW'(SYMS-1));
    done     = win_end & (~one_ok | last_sym);

    cand_d    = cand;
    hit_d     = hit;
    have_d    = have;
    multi_d   = multi;
    in_gap_d  = in_gap;
    sym_cnt_d = sym_cnt;
    acc_d     = acc;
    word_d    = word_o;
    perr_d    = parity_err_o;
    valid_d   = 1'b0;
    serr_d    = 1'b0;

    if (clr) begin
      have_d    = 1'b0;
      multi_d   = 1'b0;
      in_gap_d  = 1'b0;
      sym_cnt_d = '0;
    end else if (win_end) begin
      have_d   = 1'b0;
      multi_d  = 1'b0;
      in_gap_d = 1'b0;
      if (one_ok) begin
        acc_d = acc_nx;
        if (last_sym) begin
          word_d    = acc_nx;
          perr_d    = ^acc_nx;
          valid_d   = 1'b1;
          sym_cnt_d = '0;
        end else begin
          sym_cnt_d = sym_cnt + 1'b1;
        end
      end else begin
        serr_d    = 1'b1;
        sym_cnt_d = '0;
      end
    end else if (run) begin
      if (fall) begin
        in_gap_d = 1'b1;
        cand_d   = slot;
      end
      if (rise)
        in_gap_d = 1'b0;
      if (comp) begin
        if (have) multi_d = 1'b1;
        else begin
          have_d = 1'b1;
          hit_d  = cand;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand         <= '0;
      hit          <= '0;
      have         <= 1'b0;
      multi        <= 1'b0;
      in_gap       <= 1'b0;
      sym_cnt      <= '0;
      acc          <= '0;
      word_o       <= '0;
      parity_err_o <= 1'b0;
      word_valid_o <= 1'b0;
      sym_err_o    <= 1'b0;
    end else begin
      cand         <= cand_d;
      hit          <= hit_d;
      have         <= have_d;
      multi        <= multi_d;
      in_gap       <= in_gap_d;
      sym_cnt      <= sym_cnt_d;
      acc          <= acc_d;
      word_o       <= word_d;
      parity_err_o <= perr_d;
      word_valid_o <= valid_d;
      sym_err_o    <= serr_d;
    end
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (word_valid_o || $stable(word_o))); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o); // R9
  AST_SERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_err_o |=> !sym_err_o); // R7
endmodule

// File: rtl/ppm_sym_decoder.sv
`timescale 1ns/1ps
module ppm_sym_decoder
  import ppm_pkg::*;
#(
  parameter int POS_N  = 16,
  parameter int POS_F  = 8,
  parameter int GMIN_N = 3,
  parameter int GMAX_N = 10,
  parameter int GMIN_F = 2,
  parameter int GMAX_F = 4,
  parameter int SYMS   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    fast_mode,
  input  logic                    gap_n,
  output logic [SYMS*NIB_W-1:0]   word_o,
  output logic                    word_valid_o,
  output logic                    parity_err_o,
  output logic                    sym_err_o
);
  localparam int POS_MAX = (POS_N > POS_F) ? POS_N : POS_F;
  localparam int GAP_MAX = (GMAX_N > GMAX_F) ? GMAX_N : GMAX_F;
  localparam int PW      = $clog2(POS_MAX + 1);
  localparam int CW      = $clog2(GAP_MAX + 2);

  logic [1:0]       rs;
  logic             rst_n_s;
  dec_st_e          st_q, st_d;
  logic             mode_q, mode_d, start, run, done;
  logic             fall, rise, rise_ok, win_end;
  logic [PW-1:0]    pos_len;
  logic [CW-1:0]    min_w, max_w;
  logic [NIB_W-1:0] slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= 2'b00;
    else        rs <= {rs[0], 1'b1};
  end
  assign rst_n_s = rs[1];

  always_comb begin
    pos_len = mode_q ? PW'(POS_F)  : PW'(POS_N);
    min_w   = mode_q ? CW'(GMIN_F) : CW'(GMIN_N);
    max_w   = mode_q ? CW'(GMAX_F) : CW'(GMAX_N);
    run     = (st_q == ST_RUN);
  end

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    start  = 1'b0;
    case (st_q)
      ST_IDLE: if (fall) begin
        st_d   = ST_CAL;
        mode_d = fast_mode;
      end
      ST_CAL: if (rise) begin
        if (rise_ok) begin
          st_d  = ST_RUN;
          start = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_RUN: if (done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
    end
  end

  ppm_gap_meter #(.CW(CW)) u_meter (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .gap(~gap_n),
    .min_w(min_w), .max_w(max_w),
    .fall(fall), .rise(rise), .rise_ok(rise_ok)
  );

  ppm_slot_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .start(start), .run(run),
    .pos_len(pos_len), .slot(slot), .win_end(win_end)
  );

  ppm_word_asm #(.SYMS(SYMS)) u_asm (
    .clk(clk), .rst_n(rst_n_s), .run(run), .clr(start),
    .fall(fall), .rise(rise), .rise_ok(rise_ok), .slot(slot), .win_end(win_end),
    .word_o(word_o), .word_valid_o(word_valid_o), .parity_err_o(parity_err_o),
    .sym_err_o(sym_err_o), .done(done)
  );

  AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n_s)
    word_valid_o |-> $past(st_q == ST_RUN)); // R9
  AST_SERR_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n_s)
    sym_err_o |-> $past(st_q == ST_RUN)); // R7
  AST_BAD_CAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_CAL && rise && !rise_ok) |=> (st_q == ST_IDLE)); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_RUN && $past(st_q) == ST_RUN) |-> $stable(mode_q)); // R11
endmodule

// File: tb/sim_ppm_sym_decoder.sv
`timescale 1ns/1ps
module sim_ppm_sym_decoder;
  localparam int PN = 16, PF = 8;
  localparam int GMINN = 3, GMAXN = 10, GMINF = 2, GMAXF = 4;
  localparam int LMAX = 3*16*PN;

  logic clk, rst_n, tick, fast_mode, gap_n;
  logic [11:0] word_o;
  logic word_valid_o, parity_err_o, sym_err_o;

  int checks = 0, errors = 0, nvalid = 0, nserr = 0;
  logic lv [0:LMAX-1];

  ppm_sym_decoder u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fast_mode(fast_mode), .gap_n(gap_n),
    .word_o(word_o), .word_valid_o(word_valid_o), .parity_err_o(parity_err_o),
    .sym_err_o(sym_err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (word_valid_o) nvalid++;
    if (sym_err_o) nserr++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v);
    @(negedge clk);
    gap_n = v;
  endtask

  task automatic clear_lv();
    for (int i = 0; i < LMAX; i++) lv[i] = 1'b1;
  endtask

  task automatic put_gap(input int s, input int pos, input int off, input int w, input int p);
    for (int i = 0; i < w; i++) lv[s*16*p + pos*p + off + i] = 1'b0;
  endtask

  task automatic play(input bit mode, input int calw, input int p, input bit flip);
    fast_mode = mode;
    repeat (4) drive(1'b1);
    repeat (calw) drive(1'b0);
    if (flip) fast_mode = ~mode;
    for (int t = 0; t < 48*p; t++) drive(lv[t]);
  endtask

  function automatic logic [11:0] mk(input int a, input int b, input int c);
    return {a[3:0], b[3:0], c[3:0]};
  endfunction

  task automatic expect_word(input logic [11:0] exp, input string tag);
    @(negedge clk);
    chk(word_valid_o == 1'b1, {"R9 valid strobe ", tag}, word_valid_o, 1);
    chk(word_o == exp, {"R3 word ", tag}, word_o, exp);
    chk(parity_err_o == ^exp, {"R10 parity ", tag}, parity_err_o, ^exp);
    gap_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic good_frame(input bit mode, input int n0, input int n1, input int n2,
                            input int o0, input int o1, input int o2, input int w,
                            input string tag);
    int p;
    p = mode ? PF : PN;
    clear_lv();
    put_gap(0, n0, o0, w, p);
    put_gap(1, n1, o1, w, p);
    put_gap(2, n2, o2, w, p);
    play(mode, w, p, 1'b0);
    expect_word(mk(n0, n1, n2), tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8*190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int v0, s0, p, gmin, gmax, w, om, o;
    int n [3];
    int of [3];
    logic [11:0] hold;
    bit m;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; tick = 1'b1; fast_mode = 1'b0; gap_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(word_o == 12'h000, "R1 reset word", word_o, 0);
    chk(word_valid_o == 1'b0, "R1 reset valid", word_valid_o, 0);
    chk(parity_err_o == 1'b0, "R1 reset parity", parity_err_o, 0);
    chk(sym_err_o == 1'b0, "R1 reset symerr", sym_err_o, 0);

    // R4 directed normal frame, even parity
    good_frame(1'b0, 4'hA, 4'h5, 4'h3, 2, 5, 1, 4, "R4 normal A53");
    // R3 boundary: exactly on boundary (off 0) and last tick before one (off P-1)
    good_frame(1'b0, 1, 6, 15, 0, PN-1, 0, GMINN, "R3 boundary normal");
    // R5 fast mode
    good_frame(1'b1, 4'hF, 4'h0, 4'h9, 0, 0, 3, GMAXF, "R5 fast F09");
    good_frame(1'b1, 2, 3, 14, 0, PF-1, 1, GMINF, "R3 boundary fast");
    // R10 odd-parity word
    good_frame(1'b0, 0, 0, 1, 1, 3, 2, GMAXN, "R10 odd word 001");

    // R9 word holds after strobe
    hold = word_o;
    repeat (40) @(negedge clk);
    chk(word_o == hold, "R9 word hold", word_o, hold);

    // R6 glitches next to legal gaps, both modes
    for (int md = 0; md < 2; md++) begin
      p = md ? PF : PN;
      gmin = md ? GMINF : GMINN;
      gmax = md ? GMAXF : GMAXN;
      clear_lv();
      put_gap(0, 4, 1, gmin, p);
      put_gap(0, 10, 0, gmin-1, p);
      put_gap(1, 0, 1, gmax+1, p);
      put_gap(1, 12, 0, gmax, p);
      put_gap(2, 7, 0, gmin, p);
      put_gap(2, 13, 0, 1, p);
      play(md[0], gmin, p, 1'b0);
      expect_word(12'h4C7, "R6 glitch");
    end

    // R7 empty window, then R11 recovery
    v0 = nvalid; s0 = nserr;
    clear_lv();
    put_gap(0, 8, 0, 4, PN);
    play(1'b0, 4, PN, 1'b0);
    repeat (30) @(negedge clk);
    chk(nserr - s0 == 1, "R7 empty window error", nserr - s0, 1);
    chk(nvalid - v0 == 0, "R7 word discarded", nvalid - v0, 0);
    good_frame(1'b0, 3, 3, 3, 4, 4, 4, 5, "R11 recover after error");

    // R8 two legal gaps in one window
    v0 = nvalid; s0 = nserr;
    clear_lv();
    put_gap(0, 5, 0, 2, PF);
    put_gap(1, 6, 0, 2, PF);
    put_gap(2, 2, 0, 2, PF);
    put_gap(2, 9, 0, 3, PF);
    play(1'b1, 3, PF, 1'b0);
    repeat (30) @(negedge clk);
    chk(nserr - s0 == 1, "R8 double gap error", nserr - s0, 1);
    chk(nvalid - v0 == 0, "R8 word discarded", nvalid - v0, 0);

    // R2 calibration out of range: too long and too short
    for (int k = 0; k < 2; k++) begin
      v0 = nvalid; s0 = nserr;
      clear_lv();
      play(1'b0, k ? GMINN-1 : GMAXN+1, PN, 1'b0);
      repeat (30) @(negedge clk);
      chk(nserr - s0 == 0, "R2 bad calibration no error", nserr - s0, 0);
      chk(nvalid - v0 == 0, "R2 bad calibration no word", nvalid - v0, 0);
    end

    // R11 mode toggled mid-command
    clear_lv();
    put_gap(0, 9, 3, 6, PN);
    put_gap(1, 1, 0, 6, PN);
    put_gap(2, 12, 5, 6, PN);
    play(1'b0, 6, PN, 1'b1);
    expect_word(12'h91C, "R11 mode held");
    fast_mode = 1'b0;

    // random frames, R3 R9 R10
    for (int f = 0; f < 24; f++) begin
      m = $urandom % 2;
      p = m ? PF : PN;
      gmin = m ? GMINF : GMINN;
      gmax = m ? GMAXF : GMAXN;
      w = gmin + ($urandom % (gmax - gmin + 1));
      clear_lv();
      for (int s = 0; s < 3; s++) begin
        n[s] = $urandom % 16;
        om = p - 1 - w;
        o = $urandom % (om + 1);
        if (s == 0 && n[s] == 0 && o == 0) o = 1;
        of[s] = o;
        put_gap(s, n[s], of[s], w, p);
      end
      play(m, gmin + ($urandom % (gmax - gmin + 1)), p, 1'b0);
      expect_word(mk(n[0], n[1], n[2]), "random");
    end

    summary();
    $finish;
  end
endmodule